// File: doc/BRIEF.md
# Priority Next-Interrupt Selector

This block sits between the external interrupt arrays of a processor core and its trap logic. Each cycle it takes the per-IRQ pending, enable and priority vectors, plus two preemption levels held elsewhere. It derives two results. The first is the core-level external interrupt request, gated by the current preemption level. The second is the word that software reads from the next-interrupt CSR, gated by the previous preemption level. That word tells the handler dispatcher which IRQ to service. It carries the IRQ number pre-shifted by two so that it can index a table of 32-bit handler pointers. Its sign bit is set when nothing qualifies.

Two side effects go out as one-cycle strobes on the clock edge after the CSR access. A read that reports a real IRQ asks the force-array owner to drop that IRQ's force bit. A write with the update bit set hands the selected IRQ number, its priority and the no-IRQ flag to the context block. The arrays and the context stack live outside this block.

Top module: `irq_next_sel`

## Requirements
- R1: `ext_irq_pending` is high in the same cycle exactly when some IRQ is pending, enabled and has a priority (zero-extended) greater than or equal to `cur_lvl`. A `cur_lvl` of 2^PRIO_W masks every IRQ.
- R2: The selected IRQ is the pending and enabled IRQ with the highest priority among those whose priority is greater than or equal to `prev_lvl`. IRQs below `prev_lvl` are invisible to the selection even when they are pending and enabled.
- R3: When several qualifying IRQs share the highest priority, the lowest-numbered one is selected.
- R4: `csr_rdata` carries the selected IRQ number in bits 10:2 (the number shifted left by two) and bit 31 clear. When no IRQ qualifies, bit 31 is set and bits 10:2 are zero. All other bits always read zero.
- R5: One cycle after a cycle with `csr_rd` high and bit 31 of `csr_rdata` clear, `frc_clr_valid` pulses for one cycle with `frc_clr_idx` equal to the IRQ read. A read that reports no IRQ, or a cycle without a read, produces no pulse. This holds whether or not an update is written.
- R6: One cycle after a cycle with `csr_wr` and `csr_wdata0` both high, `ctx_upd_valid` pulses for one cycle. With it come `ctx_upd_irq` and `ctx_upd_prio` (the selected IRQ and its priority, both zero when none) and `ctx_upd_none` (the no-IRQ flag). A write with `csr_wdata0` low produces no pulse.
- R7: While `rst_n` is low, `frc_clr_valid` and `ctx_upd_valid` are low regardless of the access inputs.
- R8: The two thresholds are independent. An IRQ with `prev_lvl <= prio < cur_lvl` is reported by the CSR read while `ext_irq_pending` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | NUM_IRQ | Pending flag per IRQ |
| irq_en | input | NUM_IRQ | Enable flag per IRQ |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per IRQ, IRQ i in bits i*PRIO_W +: PRIO_W |
| cur_lvl | input | PRIO_W+1 | Current preemption level (gates the core request) |
| prev_lvl | input | PRIO_W+1 | Previous preemption level (gates the CSR selection) |
| csr_rd | input | 1 | Next-interrupt CSR is read this cycle |
| csr_wr | input | 1 | Next-interrupt CSR is written this cycle |
| csr_wdata0 | input | 1 | Bit 0 (update) of the write data |
| ext_irq_pending | output | 1 | Core-level external interrupt request |
| csr_rdata | output | 32 | Next-interrupt CSR read value |
| frc_clr_valid | output | 1 | Request to clear one force bit |
| frc_clr_idx | output | IRQ_W | IRQ whose force bit is to be cleared |
| ctx_upd_valid | output | 1 | Context update strobe |
| ctx_upd_irq | output | IRQ_W | IRQ number for the context block |
| ctx_upd_prio | output | PRIO_W | Priority of that IRQ |
| ctx_upd_none | output | 1 | No IRQ qualified at the update |

## Verification
`ext_irq_pending` and `csr_rdata` are combinational. The bench checks them one time unit after it drives new inputs at the falling edge, inside the same cycle. The force-clear and context-update strobes come from one register stage. The bench therefore keeps the expectation formed in the stimulus cycle and checks it at the next falling edge, before the new stimulus is applied. The reference model finds the winner by walking priority levels downward and IRQ numbers upward. It covers directed ties, empty and fully masked sets, and split thresholds, then random vectors of varying density.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int CSR_W     = 32;
    localparam int NONE_BIT  = 31;
    localparam int IDX_LSB   = 2;
    localparam int IDX_FIELD = 9;   // bits 10:2, so NUM_IRQ may not exceed 512
    localparam int UPD_BIT   = 0;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4,
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [LVL_W-1:0]          cur_lvl,
    input  logic [LVL_W-1:0]          prev_lvl,
    output logic [NUM_IRQ-1:0]        core_hit,
    output logic [NUM_IRQ-1:0]        sel_hit
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        logic             live;
        logic [LVL_W-1:0] prio_x;
        assign live        = irq_pend[g] & irq_en[g];
        assign prio_x      = {1'b0, irq_prio[g*PRIO_W +: PRIO_W]};
        assign core_hit[g] = live && (prio_x >= cur_lvl);
        assign sel_hit[g]  = live && (prio_x >= prev_lvl);
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4,
    localparam int IRQ_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]        hit,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    output logic                      found,
    output logic [IRQ_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Ascending scan; strict greater-than keeps the lowest number on ties.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (hit[i] && (!found || irq_prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
                found    = 1'b1;
                win_idx  = IRQ_W'(i);
                win_prio = irq_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_next_sel.sv
module irq_next_sel
    import irqsel_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4,
    localparam int LVL_W  = PRIO_W + 1,
    localparam int IRQ_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [LVL_W-1:0]          cur_lvl,
    input  logic [LVL_W-1:0]          prev_lvl,
    input  logic                      csr_rd,
    input  logic                      csr_wr,
    input  logic                      csr_wdata0,
    output logic                      ext_irq_pending,
    output logic [CSR_W-1:0]          csr_rdata,
    output logic                      frc_clr_valid,
    output logic [IRQ_W-1:0]          frc_clr_idx,
    output logic                      ctx_upd_valid,
    output logic [IRQ_W-1:0]          ctx_upd_irq,
    output logic [PRIO_W-1:0]         ctx_upd_prio,
    output logic                      ctx_upd_none
);
    typedef struct packed {
        logic              clr_v;
        logic [IRQ_W-1:0]  clr_idx;
        logic              upd_v;
        logic [IRQ_W-1:0]  upd_irq;
        logic [PRIO_W-1:0] upd_prio;
        logic              upd_none;
    } strobe_t;

    logic [NUM_IRQ-1:0] core_hit;
    logic [NUM_IRQ-1:0] sel_hit;
    logic               found;
    logic [IRQ_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    strobe_t            st_d, st_q;

    irq_qualify #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_qual (
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .irq_prio (irq_prio),
        .cur_lvl  (cur_lvl),
        .prev_lvl (prev_lvl),
        .core_hit (core_hit),
        .sel_hit  (sel_hit)
    );

    irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .hit      (sel_hit),
        .irq_prio (irq_prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    assign ext_irq_pending = |core_hit;

    always_comb begin
        csr_rdata = '0;
        csr_rdata[NONE_BIT] = ~found;
        if (found) csr_rdata[IDX_LSB +: IRQ_W] = win_idx;
    end

    always_comb begin
        st_d          = '0;
        st_d.clr_v    = csr_rd & found;
        st_d.clr_idx  = found ? win_idx : '0;
        st_d.upd_v    = csr_wr & csr_wdata0;
        st_d.upd_irq  = found ? win_idx : '0;
        st_d.upd_prio = found ? win_prio : '0;
        st_d.upd_none = ~found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frc_clr_valid = st_q.clr_v;
    assign frc_clr_idx   = st_q.clr_idx;
    assign ctx_upd_valid = st_q.upd_v;
    assign ctx_upd_irq   = st_q.upd_irq;
    assign ctx_upd_prio  = st_q.upd_prio;
    assign ctx_upd_none  = st_q.upd_none;
endmodule

// File: rtl/irq_next_sel_chk.sv
module irq_next_sel_chk #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4,
    localparam int IRQ_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic               csr_rd,
    input logic               csr_wr,
    input logic               csr_wdata0,
    input logic               ext_irq_pending,
    input logic [31:0]        csr_rdata,
    input logic               frc_clr_valid,
    input logic [IRQ_W-1:0]   frc_clr_idx,
    input logic               ctx_upd_valid,
    input logic [IRQ_W-1:0]   ctx_upd_irq,
    input logic               ctx_upd_none
);
    AST_REQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq_pending |-> |(irq_pend & irq_en)); // R1
    AST_SEL_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[31] |-> |(irq_pend & irq_en)); // R2
    AST_NONE_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[31] |-> (csr_rdata[10:2] == '0)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[30:11] == '0) && (csr_rdata[1:0] == '0)); // R4
    AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        frc_clr_valid |-> ($past(csr_rd) && !$past(csr_rdata[31]))); // R5
    AST_CLR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        frc_clr_valid |-> (frc_clr_idx == $past(csr_rdata[2 +: IRQ_W]))); // R5
    AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_upd_valid |-> $past(csr_wr && csr_wdata0)); // R6
    AST_UPD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_upd_valid |-> (ctx_upd_none == $past(csr_rdata[31]))); // R6
    AST_UPD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_upd_valid |-> (ctx_upd_irq == $past(csr_rdata[2 +: IRQ_W]))); // R6
    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (!frc_clr_valid && !ctx_upd_valid); // R7
    end
endmodule

bind irq_next_sel irq_next_sel_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .irq_pend        (irq_pend),
    .irq_en          (irq_en),
    .csr_rd          (csr_rd),
    .csr_wr          (csr_wr),
    .csr_wdata0      (csr_wdata0),
    .ext_irq_pending (ext_irq_pending),
    .csr_rdata       (csr_rdata),
    .frc_clr_valid   (frc_clr_valid),
    .frc_clr_idx     (frc_clr_idx),
    .ctx_upd_valid   (ctx_upd_valid),
    .ctx_upd_irq     (ctx_upd_irq),
    .ctx_upd_none    (ctx_upd_none)
);

// File: tb/irq_next_sel_tb.sv
module irq_next_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int P  = 4;
    localparam int L  = P + 1;
    localparam int IW = $clog2(N);
    localparam int NLEV = 1 << P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   pend = '0, en = '0;
    logic [N*P-1:0] prio = '0;
    logic [L-1:0]   cur = '0, prev = '0;
    logic rd = 1'b0, wr = 1'b0, w0 = 1'b0;
    logic ext_pend;
    logic [31:0] rdata;
    logic clr_v, upd_v, upd_none;
    logic [IW-1:0] clr_idx, upd_irq;
    logic [P-1:0] upd_prio;

    int checks = 0, errors = 0;
    bit e_clr_v = 0, e_upd_v = 0, e_none = 1;
    int e_clr_idx = 0, e_irq = 0, e_prio = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_next_sel #(.NUM_IRQ(N), .PRIO_W(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_prio(prio),
        .cur_lvl(cur), .prev_lvl(prev), .csr_rd(rd), .csr_wr(wr), .csr_wdata0(w0),
        .ext_irq_pending(ext_pend), .csr_rdata(rdata),
        .frc_clr_valid(clr_v), .frc_clr_idx(clr_idx),
        .ctx_upd_valid(upd_v), .ctx_upd_irq(upd_irq),
        .ctx_upd_prio(upd_prio), .ctx_upd_none(upd_none)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int prio_of(int i);
        return int'(prio[i*P +: P]);
    endfunction

    // Registered strobes formed in the previous cycle.
    task automatic check_strobes();
        chk("R5 clr_valid", clr_v, e_clr_v);
        if (e_clr_v) chk("R5 clr_idx", clr_idx, e_clr_idx);
        chk("R6 upd_valid", upd_v, e_upd_v);
        if (e_upd_v) begin
            chk("R6 upd_irq", upd_irq, e_irq);
            chk("R6 upd_prio", upd_prio, e_prio);
            chk("R6 upd_none", upd_none, e_none);
        end
    endtask

    task automatic step(input logic [N-1:0] p_i, input logic [N-1:0] e_i,
                        input logic [N*P-1:0] pr_i, input int c_i, input int pv_i,
                        input bit rd_i, input bit wr_i, input bit w0_i, input string tag);
        bit mp, fnd;
        int idx, pr;
        logic [31:0] exp_word;
        @(negedge clk);
        check_strobes();
        pend = p_i; en = e_i; prio = pr_i; cur = L'(c_i); prev = L'(pv_i);
        rd = rd_i; wr = wr_i; w0 = w0_i;
        #1;
        mp = 0;
        for (int i = 0; i < N; i++)
            if (pend[i] && en[i] && prio_of(i) >= c_i) mp = 1;
        fnd = 0; idx = 0; pr = 0;
        for (int lv = NLEV - 1; lv >= 0 && !fnd; lv--)
            for (int i = 0; i < N && !fnd; i++)
                if (pend[i] && en[i] && prio_of(i) == lv && lv >= pv_i) begin
                    fnd = 1; idx = i; pr = lv;
                end
        exp_word = fnd ? (32'(idx) << 2) : 32'h8000_0000;
        chk({"R1 ", tag}, ext_pend, mp);
        chk({"R2 R3 R4 R8 ", tag}, rdata, exp_word);
        e_clr_v = rd_i && fnd; e_clr_idx = idx;
        e_upd_v = wr_i && w0_i; e_irq = idx; e_prio = pr; e_none = !fnd;
    endtask

    function automatic logic [N*P-1:0] set_prio(logic [N*P-1:0] base, int i, int v);
        logic [N*P-1:0] r = base;
        r[i*P +: P] = P'(v);
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N*P-1:0] pv;
        // R7: strobes stay low in reset despite live accesses
        pend = '1; en = '1; rd = 1; wr = 1; w0 = 1;
        repeat (3) begin
            @(negedge clk);
            chk("R7 clr_valid in reset", clr_v, 0);
            chk("R7 upd_valid in reset", upd_v, 0);
        end
        pend = '0; en = '0; rd = 0; wr = 0; w0 = 0;
        @(negedge clk);
        rst_n = 1'b1;

        // Empty set, read and update: no clear, update reports none (R4 R5 R6)
        step('0, '1, '0, 0, 0, 1, 1, 1, "empty");
        // Pending but disabled
        step('1, '0, '1, 0, 0, 1, 0, 0, "disabled");
        // Ties at one level: lowest number wins (R3)
        pv = '0;
        pv = set_prio(pv, 3, 5); pv = set_prio(pv, 7, 5); pv = set_prio(pv, 20, 5);
        step(32'h0010_0088, '1, pv, 0, 0, 1, 1, 1, "tie");
        // Highest priority at top index beats low index (R2)
        pv = set_prio('0, 31, 9);
        step(32'h8000_0001, '1, pv, 0, 0, 1, 1, 0, "top index");
        // Split thresholds: visible to read, not to core (R8)
        pv = set_prio('0, 4, 3);
        step(32'h0000_0010, '1, pv, 5, 2, 1, 0, 0, "split");
        // Below previous level: hidden from selection (R2)
        pv = set_prio('0, 4, 1);
        step(32'h0000_0010, '1, pv, 0, 2, 1, 1, 1, "below prev");
        // Fully masked levels (R1)
        step('1, '1, '1, NLEV, NLEV, 1, 1, 1, "masked");
        // Level exactly equal to priority qualifies (R1 R2)
        step('1, '1, '1, NLEV - 1, NLEV - 1, 1, 0, 1, "equal");
        // Write without update bit: no context strobe (R6)
        step('1, '1, '1, 0, 0, 0, 1, 0, "wr no upd");

        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] rp, re;
            logic [N*P-1:0] rpr;
            rp = N'($urandom()); re = N'($urandom());
            if (n % 3 == 0) rp = rp & N'($urandom());
            if (n % 5 == 0) rp = rp & N'($urandom()) & N'($urandom());
            for (int k = 0; k < N; k++) rpr[k*P +: P] = P'($urandom_range(0, (n % 4 == 0) ? 2 : NLEV - 1));
            step(rp, re, rpr, $urandom_range(0, NLEV), $urandom_range(0, NLEV),
                 1'($urandom()), 1'($urandom()), 1'($urandom()), "random");
        end
        step('0, '0, '0, 0, 0, 0, 0, 0, "flush");
        @(negedge clk);
        check_strobes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule